// File: doc/BRIEF.md
# Scan-Capable Shadow Pipeline Register

This block is a parallel pipeline register with a second register of the same width placed beside it. The second register is the shadow register. The pipeline register carries normal data from the parallel input port to the Y outputs. The shadow register gives test and load access to that data path:

- It can shift serially, so that many blocks strung together form one long scan chain.
- It can capture what the pipeline register holds.
- It can hand its own contents to the pipeline register.
- It can drive its contents backwards out of the parallel input port, for example to write a control-store word that was shifted in serially.

Each register has its own clock, and the two clocks are independent. When both clocks rise together, the two registers exchange contents in one step. A mode input and the serial input together choose the shadow operation. When mode is high, the serial output repeats the serial input, so the mode selection passes down a cascade.

Top module: `scan_shadow_pipe`

## Requirements
- R1: An active-low asynchronous reset clears both the pipeline register and the shadow register to zero at once, with no clock edge needed.
- R2: With mode low, each rising edge of the pipeline clock loads the pipeline register from `d_i`.
- R3: With mode low, each rising edge of the shadow clock shifts the shadow register one place toward its MSB. Bit i takes bit i-1, bit 0 takes `sdi_i`, and `sdo_o` shows the shadow MSB.
- R4: With mode high, each rising edge of the pipeline clock loads the pipeline register from the shadow register.
- R5: With mode high and `sdi_i` low, each rising edge of the shadow clock loads the shadow register from the internal pipeline register value. This works even while the Y outputs are disabled.
- R6: With mode high and `sdi_i` high, the shadow register keeps its value on shadow clock edges. `d_oe_o` is 1 and `d_o` equals the shadow contents.
- R7: `d_oe_o` is 0 in every other combination of mode and `sdi_i`.
- R8: With mode high, `sdo_o` equals `sdi_i` combinationally.
- R9: With `oe_ni` low, `y_valid_o` is 1 and `y_o` shows the pipeline register. With `oe_ni` high, `y_valid_o` is 0 and `y_o` is all zeros, and the pipeline register keeps its value.
- R10: Rising edges of the two clocks at the same instant both take effect. With mode high and `sdi_i` low, the two registers exchange contents.
- R11: Chaining N blocks, each `sdo_o` feeding the next block's `sdi_i`, with mode low gives an N×WIDTH-bit scan chain. The first bit shifted in reaches the last `sdo_o` after exactly N×WIDTH shadow clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk_i | input | 1 | Pipeline register clock, rising edge |
| dclk_i | input | 1 | Shadow register clock, rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_i | input | 1 | 0: shift and parallel load, 1: transfer, capture, hold and drive back |
| sdi_i | input | 1 | Serial input; also chooses capture (0) or hold-and-drive (1) when mode is high |
| sdo_o | output | 1 | Serial output: shadow MSB when mode is low, `sdi_i` when mode is high |
| d_i | input | WIDTH | Parallel data input |
| d_o | output | WIDTH | Shadow contents driven back toward the data port |
| d_oe_o | output | 1 | Enable for `d_o` onto the data port |
| oe_ni | input | 1 | Active-low enable for the Y outputs |
| y_o | output | WIDTH | Pipeline register contents; zero when disabled |
| y_valid_o | output | 1 | High when `y_o` is enabled |

## Verification
The hardest case to reach from the ports is the exchange: both clocks must rise at the same instant while mode is high and `sdi_i` is low. Before that, the two registers must hold different, known values. The bench first loads the pipeline register from `d_i` and shifts a different byte serially into the shadow register. It then pulses both clocks together. Y shows the old shadow byte. The old pipeline byte is read back through `d_o` after raising `sdi_i`. Capture while Y is disabled is reached the same way: the shadow contents are read back through the drive-back path rather than through the Y outputs.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  localparam int unsigned DEF_WIDTH = 8;

  typedef enum logic [1:0] {
    SH_SHIFT   = 2'd0,
    SH_CAPTURE = 2'd1,
    SH_HOLD    = 2'd2
  } shadow_op_e;
endpackage

// File: rtl/ssp_mode_dec.sv
module ssp_mode_dec
  import ssp_pkg::*;
(
  input  logic       mode_i,
  input  logic       sdi_i,
  input  logic       shadow_msb_i,
  output shadow_op_e shadow_op_o,
  output logic       pipe_from_shadow_o,
  output logic       drive_back_o,
  output logic       sdo_o
);
  always_comb begin
    if (!mode_i)     shadow_op_o = SH_SHIFT;
    else if (!sdi_i) shadow_op_o = SH_CAPTURE;
    else             shadow_op_o = SH_HOLD;
  end

  assign pipe_from_shadow_o = mode_i;
  assign drive_back_o       = mode_i & sdi_i;
  // mode high: pass sdi so a cascade sees the same selection
  assign sdo_o              = mode_i ? sdi_i : shadow_msb_i;
endmodule

// File: rtl/ssp_shadow_reg.sv
module ssp_shadow_reg
  import ssp_pkg::*;
#(
  parameter int unsigned WIDTH = DEF_WIDTH
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  shadow_op_e       op_i,
  input  logic             sdi_i,
  input  logic [WIDTH-1:0] cap_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] q_d;

  always_comb begin
    unique case (op_i)
      SH_SHIFT:   q_d = {q_o[WIDTH-2:0], sdi_i};
      SH_CAPTURE: q_d = cap_i;
      default:    q_d = q_o;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= q_d;
  end

  p_shift_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == SH_SHIFT) |=> (q_o == {$past(q_o[WIDTH-2:0]), $past(sdi_i)}));
  p_capture_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == SH_CAPTURE) |=> (q_o == $past(cap_i)));
  p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == SH_HOLD) |=> $stable(q_o));
endmodule

// File: rtl/ssp_pipe_reg.sv
module ssp_pipe_reg
  import ssp_pkg::*;
#(
  parameter int unsigned WIDTH = DEF_WIDTH
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             from_shadow_i,
  input  logic [WIDTH-1:0] d_i,
  input  logic [WIDTH-1:0] shadow_i,
  output logic [WIDTH-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            q_o <= '0;
    else if (from_shadow_i) q_o <= shadow_i;
    else                    q_o <= d_i;
  end

  p_load_d_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !from_shadow_i |=> (q_o == $past(d_i)));
  p_load_shadow_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    from_shadow_i |=> (q_o == $past(shadow_i)));
endmodule

// File: rtl/scan_shadow_pipe.sv
module scan_shadow_pipe
  import ssp_pkg::*;
#(
  parameter int unsigned WIDTH = DEF_WIDTH
) (
  input  logic             pclk_i,
  input  logic             dclk_i,
  input  logic             rst_ni,
  input  logic             mode_i,
  input  logic             sdi_i,
  output logic             sdo_o,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] d_o,
  output logic             d_oe_o,
  input  logic             oe_ni,
  output logic [WIDTH-1:0] y_o,
  output logic             y_valid_o
);
  localparam int unsigned MSB = WIDTH - 1;

  shadow_op_e       shadow_op;
  logic             pipe_from_shadow;
  logic [WIDTH-1:0] shadow_q;
  logic [WIDTH-1:0] pipe_q;

  ssp_mode_dec i_dec (
    .mode_i             (mode_i),
    .sdi_i              (sdi_i),
    .shadow_msb_i       (shadow_q[MSB]),
    .shadow_op_o        (shadow_op),
    .pipe_from_shadow_o (pipe_from_shadow),
    .drive_back_o       (d_oe_o),
    .sdo_o              (sdo_o)
  );

  // capture taps the register, not the gated Y outputs
  ssp_shadow_reg #(.WIDTH(WIDTH)) i_shadow (
    .clk_i  (dclk_i),
    .rst_ni (rst_ni),
    .op_i   (shadow_op),
    .sdi_i  (sdi_i),
    .cap_i  (pipe_q),
    .q_o    (shadow_q)
  );

  ssp_pipe_reg #(.WIDTH(WIDTH)) i_pipe (
    .clk_i         (pclk_i),
    .rst_ni        (rst_ni),
    .from_shadow_i (pipe_from_shadow),
    .d_i           (d_i),
    .shadow_i      (shadow_q),
    .q_o           (pipe_q)
  );

  assign d_o       = shadow_q;
  assign y_valid_o = ~oe_ni;
  assign y_o       = oe_ni ? '0 : pipe_q;

  p_doe_r7: assert property (@(posedge dclk_i) disable iff (!rst_ni)
    d_oe_o |-> (mode_i && sdi_i));
  p_doe_on_r6: assert property (@(posedge dclk_i) disable iff (!rst_ni)
    (mode_i && sdi_i) |-> (d_oe_o && d_o == shadow_q));
  p_sdo_pass_r8: assert property (@(posedge dclk_i) disable iff (!rst_ni)
    mode_i |-> (sdo_o == sdi_i));
  p_y_off_r9: assert property (@(posedge pclk_i) disable iff (!rst_ni)
    oe_ni |-> (!y_valid_o && y_o == '0));
endmodule

// File: tb/test_scan_shadow_pipe.sv
module test_scan_shadow_pipe;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;
  localparam int N = 3;

  int checks = 0;
  int failures = 0;

  logic pclk = 0, dclk = 0, rst_n = 0, mode = 0, sdi = 0, oe_n = 0;
  logic [W-1:0] d_in = '0;
  logic [W-1:0] d_out, y;
  logic d_oe, y_valid, sdo;

  scan_shadow_pipe #(.WIDTH(W)) i_scan_shadow_pipe (
    .pclk_i(pclk), .dclk_i(dclk), .rst_ni(rst_n), .mode_i(mode), .sdi_i(sdi),
    .sdo_o(sdo), .d_i(d_in), .d_o(d_out), .d_oe_o(d_oe), .oe_ni(oe_n),
    .y_o(y), .y_valid_o(y_valid)
  );

  // cascade for R11
  logic          c_dclk = 0, c_sdi = 0;
  logic [N:0]    c_link;
  logic [W-1:0]  c_dout [N];
  logic [W-1:0]  c_y    [N];
  logic [N-1:0]  c_doe, c_yv;
  assign c_link[0] = c_sdi;
  for (genvar g = 0; g < N; g++) begin : g_chain
    scan_shadow_pipe #(.WIDTH(W)) i_stage (
      .pclk_i(1'b0), .dclk_i(c_dclk), .rst_ni(rst_n), .mode_i(1'b0),
      .sdi_i(c_link[g]), .sdo_o(c_link[g+1]), .d_i('0), .d_o(c_dout[g]),
      .d_oe_o(c_doe[g]), .oe_ni(1'b0), .y_o(c_y[g]), .y_valid_o(c_yv[g])
    );
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // both inputs settled beforehand; outputs sampled after falling edge
  task automatic pulse(input bit p, input bit d);
    #(CLK_PERIOD/2);
    pclk = p; dclk = d;
    #(CLK_PERIOD/2);
    pclk = 0; dclk = 0;
    #(CLK_PERIOD/2);
  endtask

  task automatic shift_in(input logic [W-1:0] v);
    mode = 0;
    for (int i = W-1; i >= 0; i--) begin
      sdi = v[i];
      pulse(0, 1);
    end
  endtask

  task automatic read_shadow(output logic [W-1:0] v);
    mode = 1; sdi = 1; #1;
    v = d_out;
  endtask

  task automatic t_reset;
    #(CLK_PERIOD); rst_n = 1; #(CLK_PERIOD);
    chk("R1 y", y, 0);
    chk("R1 y_valid", y_valid, 1);
    chk("R1 sdo", sdo, 0);
    chk("R7 d_oe mode0", d_oe, 0);
  endtask

  task automatic t_parallel;
    mode = 0; d_in = 8'hA5; pulse(1, 0);
    chk("R2 load A5", y, 8'hA5);
    d_in = 8'h3C; pulse(1, 0);
    chk("R2 load 3C", y, 8'h3C);
  endtask

  task automatic t_shift;
    logic [W-1:0] s;
    d_in = 8'hFF;
    shift_in(8'hC3);
    chk("R3 pipe untouched by dclk", y, 8'h3C);
    chk("R3 sdo msb", sdo, 1);
    sdi = 0; pulse(0, 1);
    chk("R3 sdo after one more shift", sdo, 1);
    read_shadow(s);
    chk("R3 shadow after 9 shifts", s, 8'h86);
  endtask

  task automatic t_hold_drive;
    logic [W-1:0] s;
    mode = 1; sdi = 1; #1;
    chk("R6 d_oe", d_oe, 1);
    chk("R6 d_o", d_out, 8'h86);
    pulse(0, 1);
    read_shadow(s);
    chk("R6 hold", s, 8'h86);
    sdi = 0; #1;
    chk("R7 d_oe capture mode", d_oe, 0);
  endtask

  task automatic t_sdo_pass;
    mode = 1; sdi = 0; #1;
    chk("R8 sdo=0", sdo, 0);
    sdi = 1; #1;
    chk("R8 sdo=1", sdo, 1);
  endtask

  task automatic t_transfer;
    mode = 1; sdi = 1; pulse(1, 0);
    chk("R4 pipe from shadow", y, 8'h86);
  endtask

  task automatic t_capture_disabled;
    logic [W-1:0] s;
    mode = 0; d_in = 8'h5A; pulse(1, 0);
    oe_n = 1; #1;
    chk("R9 y_valid off", y_valid, 0);
    chk("R9 y zero", y, 0);
    mode = 1; sdi = 0; pulse(0, 1);
    read_shadow(s);
    chk("R5 capture while disabled", s, 8'h5A);
    oe_n = 0; #1;
    chk("R9 pipe kept", y, 8'h5A);
  endtask

  task automatic t_swap;
    logic [W-1:0] s;
    shift_in(8'h81);
    mode = 1; sdi = 0; pulse(1, 1);
    chk("R10 swap y", y, 8'h81);
    read_shadow(s);
    chk("R10 swap shadow", s, 8'h5A);
  endtask

  task automatic t_async_reset;
    logic [W-1:0] s;
    #3; rst_n = 0; #2;
    chk("R1 async y", y, 0);
    read_shadow(s);
    chk("R1 async shadow", s, 0);
    #3; rst_n = 1; #(CLK_PERIOD);
  endtask

  task automatic t_cascade;
    logic [N*W-1:0] pat = 24'hB1_7E_29;
    logic [N*W-1:0] got = '0;
    for (int i = N*W-1; i >= 0; i--) begin
      c_sdi = pat[i];
      #(CLK_PERIOD/2); c_dclk = 1; #(CLK_PERIOD/2); c_dclk = 0; #(CLK_PERIOD/2);
      if (i == 1) chk("R11 not early", c_link[N], 0);
    end
    chk("R11 first bit at N*W", c_link[N], pat[N*W-1]);
    c_sdi = 0;
    for (int i = N*W-1; i >= 0; i--) begin
      got[i] = c_link[N];
      #(CLK_PERIOD/2); c_dclk = 1; #(CLK_PERIOD/2); c_dclk = 0; #(CLK_PERIOD/2);
    end
    chk("R11 chain readback", got, pat);
  endtask

  initial begin
    #(CLK_PERIOD*200000);
    failures++; checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    t_parallel();
    t_shift();
    t_hold_drive();
    t_sdo_pass();
    t_transfer();
    t_capture_disabled();
    t_swap();
    t_async_reset();
    t_cascade();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule